// File: doc/BRIEF.md
# PHY Management Register Bridge

This block gives a host a small register window onto an internal PHY management port. The host writes one command word that names a management port, a register address and an operation, then either polls a read-data register until its completion flag appears or hands over a data word and polls until hardware drops that word's pending flag. Behind the window the block runs a single transaction on a valid/ready request channel and waits for a one-cycle response pulse.

The two completion flags have opposite senses. The read flag is set by hardware when data arrives and cleared by the next command write. The write flag is set by the host, as part of the data word that launches the write, and cleared by hardware when the response returns. Only one transaction is in flight at a time. While it runs, the `busy` output is high and host writes are dropped.

Top module: `mgmt_bridge`

## Requirements
- R1: After reset all three host registers read as zero, `busy` is low and `req_valid` is low.
- R2: The command word carries the register address in bits 15:0, the port number in bits 19:16 and the operation code in bits 31:20. A launched request presents that port and address on `req_port` and `req_reg`.
- R3: Host register select 0 is the command register. Writing it with operation code 1 clears the read done flag and raises `req_valid` with `req_is_read` high in the next cycle.
- R4: Host register select 2 is the read-data register. The cycle after the response pulse of a read, it shows the returned 16-bit value in bits 15:0, zeros in bits 30:16 and a 1 in bit 31.
- R5: Writing the command register with operation code 0 arms a write and launches nothing. A later write to host register select 1 (write data) with bit 31 set launches a request in the next cycle with `req_is_read` low and bits 15:0 on `req_data`.
- R6: Bit 31 of the write-data register reads 1 from the launch of a write until the response pulse, and reads 0 in the cycle after that pulse.
- R7: A write-data write with bit 31 clear, or with no write armed (including after a completed write), launches nothing and leaves bit 31 reading 0.
- R8: `busy` is high from the launch of a transaction until the cycle after its response pulse. Command and write-data writes made while busy are dropped and leave the registers unchanged.
- R9: While `req_valid` is high and `req_ready` is low, the request and its payload hold steady.
- R10: A command word with an operation code other than 0 or 1 is stored and reads back, but launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select: 0 command, 1 write data, 2 read data |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Selected register contents |
| busy | output | 1 | Transaction in flight |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the back end |
| req_is_read | output | 1 | Request direction, 1 for read |
| req_port | output | 4 | Target management port |
| req_reg | output | 16 | Target register address |
| req_data | output | 16 | Write value |
| rsp_valid | input | 1 | One-cycle response pulse |
| rsp_data | input | 16 | Read value returned with the response |

## Verification
A launching host write shows up as `req_valid` in the very next cycle, and the bench checks the request one clock after its write strobe. The response leaves the block through one register stage. Both the read done flag and the clearing of the write pending flag are due exactly one cycle after the `rsp_valid` pulse, so the bench waits for the pulse on a falling edge and samples the host registers at the next falling edge. A back-end model with adjustable accept delay and response latency moves these events around, so the bench checks request holding during a stall and checks that writes made while busy are dropped.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;
  localparam logic [1:0] SEL_CMD   = 2'd0;
  localparam logic [1:0] SEL_WDATA = 2'd1;
  localparam logic [1:0] SEL_RDATA = 2'd2;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xact_state_e;
endpackage

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
  import mgmt_bridge_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int REG_W  = 16,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 12,
  localparam int HOST_W = REG_W + PORT_W + CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              rsp_done,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              launch,
  output logic              launch_rd,
  output logic [PORT_W-1:0] launch_port,
  output logic [REG_W-1:0]  launch_reg,
  output logic [DATA_W-1:0] launch_data
);
  localparam int PORT_LSB = REG_W;
  localparam int CMD_LSB  = REG_W + PORT_W;
  localparam int FLAG_BIT = HOST_W - 1;
  localparam int PAD_W    = HOST_W - 1 - DATA_W;
  localparam logic [CMD_W-1:0] OP_READ  = CMD_W'(1);
  localparam logic [CMD_W-1:0] OP_WRITE = '0;

  logic [HOST_W-1:0] cmd_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic              wflag_q, wflag_d, rdone_q, rdone_d, armed_q, armed_d;
  logic              cmd_wr, wd_wr, start_rd, start_wr;
  logic [CMD_W-1:0]  new_op;

  // write decode; the bridge accepts nothing while a transaction runs
  always_comb begin
    new_op   = host_wdata[HOST_W-1:CMD_LSB];
    cmd_wr   = host_we && (host_sel == SEL_CMD) && !busy;
    wd_wr    = host_we && (host_sel == SEL_WDATA) && !busy;
    start_rd = cmd_wr && (new_op == OP_READ);
    start_wr = wd_wr && host_wdata[FLAG_BIT] && armed_q;
    launch   = start_rd || start_wr;
    launch_rd = start_rd;
    // a read takes its target from the word being written, a write from the stored command
    launch_port = start_rd ? host_wdata[CMD_LSB-1:PORT_LSB] : cmd_q[CMD_LSB-1:PORT_LSB];
    launch_reg  = start_rd ? host_wdata[REG_W-1:0] : cmd_q[REG_W-1:0];
    launch_data = host_wdata[DATA_W-1:0];
  end

  // next-state for flags and captured read data
  always_comb begin
    armed_d = armed_q;
    if (cmd_wr)        armed_d = (new_op == OP_WRITE);
    else if (start_wr) armed_d = 1'b0;

    wflag_d = wflag_q;
    if (start_wr)      wflag_d = 1'b1;
    else if (rsp_done) wflag_d = 1'b0;

    rdone_d = rdone_q;
    rdata_d = rdata_q;
    if (cmd_wr) begin
      rdone_d = 1'b0;
    end else if (rsp_done && !wflag_q) begin
      rdone_d = 1'b1;
      rdata_d = rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wflag_q <= 1'b0;
      rdone_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q   <= host_wdata;
      if (wd_wr)  wdata_q <= host_wdata[DATA_W-1:0];
      rdata_q <= rdata_d;
      wflag_q <= wflag_d;
      rdone_q <= rdone_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    case (host_sel)
      SEL_CMD:   host_rdata = cmd_q;
      SEL_WDATA: host_rdata = {wflag_q, {PAD_W{1'b0}}, wdata_q};
      SEL_RDATA: host_rdata = {rdone_q, {PAD_W{1'b0}}, rdata_q};
      default:   host_rdata = '0;
    endcase
  end

  // R4
  rdone_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdone_q) |-> $past(rsp_done));
  // R6
  wflag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wflag_q) |-> $past(rsp_done));
  // R8
  busy_cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && host_sel == SEL_CMD) |=> $stable(cmd_q));
endmodule

// File: rtl/mgmt_xact_fsm.sv
module mgmt_xact_fsm
  import mgmt_bridge_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int REG_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_rd,
  input  logic [PORT_W-1:0] launch_port,
  input  logic [REG_W-1:0]  launch_reg,
  input  logic [DATA_W-1:0] launch_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_is_read,
  output logic [PORT_W-1:0] req_port,
  output logic [REG_W-1:0]  req_reg,
  output logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  output logic              busy,
  output logic              rsp_done
);
  xact_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE: if (launch)    state_d = XS_REQ;
      XS_REQ:  if (req_ready) state_d = XS_WAIT;
      XS_WAIT: if (rsp_valid) state_d = XS_IDLE;
      default:                state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= XS_IDLE;
      req_is_read <= 1'b0;
      req_port    <= '0;
      req_reg     <= '0;
      req_data    <= '0;
    end else begin
      state_q <= state_d;
      if (launch && state_q == XS_IDLE) begin
        req_is_read <= launch_rd;
        req_port    <= launch_port;
        req_reg     <= launch_reg;
        req_data    <= launch_data;
      end
    end
  end

  assign req_valid = (state_q == XS_REQ);
  assign busy      = (state_q != XS_IDLE);
  assign rsp_done  = (state_q == XS_WAIT) && rsp_valid;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_port) && $stable(req_reg)
                                   && $stable(req_data) && $stable(req_is_read)));
  // R8
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (state_q == XS_IDLE));
endmodule

// File: rtl/mgmt_bridge.sv
module mgmt_bridge
  import mgmt_bridge_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int REG_W  = 16,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            host_we,
  input  logic [1:0]                      host_sel,
  input  logic [REG_W+PORT_W+CMD_W-1:0]   host_wdata,
  output logic [REG_W+PORT_W+CMD_W-1:0]   host_rdata,
  output logic                            busy,
  output logic                            req_valid,
  input  logic                            req_ready,
  output logic                            req_is_read,
  output logic [PORT_W-1:0]               req_port,
  output logic [REG_W-1:0]                req_reg,
  output logic [DATA_W-1:0]               req_data,
  input  logic                            rsp_valid,
  input  logic [DATA_W-1:0]               rsp_data
);
  logic              launch, launch_rd, rsp_done;
  logic [PORT_W-1:0] launch_port;
  logic [REG_W-1:0]  launch_reg;
  logic [DATA_W-1:0] launch_data;

  mgmt_host_regs #(.PORT_W(PORT_W), .REG_W(REG_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .launch(launch), .launch_rd(launch_rd), .launch_port(launch_port),
    .launch_reg(launch_reg), .launch_data(launch_data)
  );

  mgmt_xact_fsm #(.PORT_W(PORT_W), .REG_W(REG_W), .DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_rd(launch_rd), .launch_port(launch_port),
    .launch_reg(launch_reg), .launch_data(launch_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_read(req_is_read),
    .req_port(req_port), .req_reg(req_reg), .req_data(req_data),
    .rsp_valid(rsp_valid), .busy(busy), .rsp_done(rsp_done)
  );
endmodule

// File: tb/mgmt_phy_model.sv
module mgmt_phy_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cfg_stall,
  input  logic [3:0]  cfg_lat,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_is_read,
  input  logic [15:0] req_reg,
  input  logic [15:0] req_data,
  output logic        rsp_valid,
  output logic [15:0] rsp_data
);
  logic [15:0] mem [16];
  logic        active, is_rd;
  logic [3:0]  scnt, lcnt, idx;
  logic [15:0] wval;

  assign req_ready = req_valid && !active && (scnt == cfg_stall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 16'hA000 | (16'(i) * 16'h0111);
      active <= 1'b0; is_rd <= 1'b0; scnt <= '0; lcnt <= '0; idx <= '0; wval <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!active) begin
        if (req_valid) begin
          if (scnt == cfg_stall) begin
            active <= 1'b1; lcnt <= '0; scnt <= '0;
            is_rd <= req_is_read; idx <= req_reg[3:0]; wval <= req_data;
          end else scnt <= scnt + 4'd1;
        end
      end else if (lcnt == cfg_lat) begin
        rsp_valid <= 1'b1;
        rsp_data  <= is_rd ? mem[idx] : 16'h0;
        if (!is_rd) mem[idx] <= wval;
        active <= 1'b0;
      end else lcnt <= lcnt + 4'd1;
    end
  end
endmodule

// File: tb/mgmt_bridge_tb_top.sv
module mgmt_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        busy, req_valid, req_ready, req_is_read, rsp_valid;
  logic [3:0]  req_port;
  logic [15:0] req_reg, req_data, rsp_data;
  logic [3:0]  cfg_stall = '0, cfg_lat = '0;
  logic [15:0] shadow [16];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mgmt_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_read(req_is_read),
    .req_port(req_port), .req_reg(req_reg), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  mgmt_phy_model model_i (
    .clk(clk), .rst_n(rst_n), .cfg_stall(cfg_stall), .cfg_lat(cfg_lat),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_read(req_is_read),
    .req_reg(req_reg), .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] s, output logic [31:0] v);
    host_sel = s; #1; v = host_rdata;
  endtask

  task automatic wait_rsp(input string tag);
    bit seen = 0;
    for (int i = 0; i < 64; i++) begin
      if (rsp_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    check({tag, " response seen"}, 32'(seen), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    host_read(2'd0, v); check("R1 cmd reg", v, 0);
    host_read(2'd1, v); check("R1 wdata reg", v, 0);
    host_read(2'd2, v); check("R1 rdata reg", v, 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 req_valid", 32'(req_valid), 0);
  endtask

  task automatic t_read(input logic [3:0] port, input logic [15:0] rg,
                        input logic [3:0] stall, input logic [3:0] lat);
    logic [31:0] v, cmd;
    cfg_stall = stall; cfg_lat = lat;
    cmd = {12'h001, port, rg};
    host_write(2'd0, cmd);
    check("R3 req_valid", 32'(req_valid), 1);
    check("R3 direction", 32'(req_is_read), 1);
    check("R2 port", 32'(req_port), 32'(port));
    check("R2 reg", 32'(req_reg), 32'(rg));
    host_read(2'd2, v); check("R3 done cleared", 32'(v[31]), 0);
    check("R8 busy", 32'(busy), 1);
    if (stall != 0) begin
      @(negedge clk);
      check("R9 hold valid", 32'(req_valid), 1);
      check("R9 hold payload", {req_port, req_reg, 11'd0, req_is_read}, {port, rg, 12'd1});
    end
    host_write(2'd0, 32'h00155AA5);
    host_read(2'd0, v); check("R8 cmd dropped", v, cmd);
    wait_rsp("R4");
    host_read(2'd2, v); check("R4 read data", v, {1'b1, 15'd0, shadow[rg[3:0]]});
    check("R8 idle", 32'(busy), 0);
  endtask

  task automatic t_write(input logic [3:0] port, input logic [15:0] rg,
                         input logic [15:0] d, input logic [3:0] lat);
    logic [31:0] v;
    cfg_stall = 0; cfg_lat = lat;
    host_write(2'd0, {12'h000, port, rg});
    check("R5 armed only", 32'(req_valid), 0);
    host_write(2'd1, {1'b1, 15'd0, d});
    check("R5 req_valid", 32'(req_valid), 1);
    check("R5 direction", 32'(req_is_read), 0);
    check("R5 data", 32'(req_data), 32'(d));
    check("R2 write target", {req_port, req_reg}, {12'd0, port, rg});
    host_read(2'd1, v); check("R6 pending", 32'(v[31]), 1);
    wait_rsp("R6");
    host_read(2'd1, v); check("R6 cleared", v, {16'd0, d});
    shadow[rg[3:0]] = d;
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    host_write(2'd1, 32'h80001234);
    check("R7 no armed write", 32'(req_valid), 0);
    host_read(2'd1, v); check("R7 flag low", v, 32'h00001234);
    host_write(2'd0, 32'h00023003);
    host_write(2'd1, 32'h00004321);
    check("R7 flag clear no launch", 32'(req_valid), 0);
    host_read(2'd1, v); check("R7 wdata stored", v, 32'h00004321);
    host_write(2'd0, 32'h00534007);
    check("R10 no launch", 32'(req_valid) | 32'(busy), 0);
    host_read(2'd0, v); check("R10 readback", v, 32'h00534007);
    host_read(2'd2, v); check("R3 cmd clears done", 32'(v[31]), 0);
    host_write(2'd1, 32'h80000001);
    check("R10 unarmed", 32'(req_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = 16'hA000 | (16'(i) * 16'h0111);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(4'h0, 16'h0005, 4'd0, 4'd0);
    t_read(4'h3, 16'h000C, 4'd2, 4'd4);
    t_write(4'h1, 16'h0005, 16'hBEEF, 4'd3);
    t_read(4'h1, 16'h0005, 4'd1, 4'd1);
    t_write(4'hF, 16'h0002, 16'h0F0F, 4'd0);
    t_ignore();
    t_read(4'h7, 16'h0002, 4'd3, 4'd7);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule